// File: doc/BRIEF.md
# Bit-Field Extract Unit

This execution unit pulls a field of any length out of a 32-bit stream word in one instruction cycle. It is meant for the syntax parser of a bitstream decoder. The stream operand holds four consecutive stream bytes packed big-endian. The byte at the lowest address sits in bits 31..24, and the next three bytes follow in descending bit order.

A second operand, the control word, carries two values. The low byte holds the field length. The three bits above it hold the starting bit offset, counted from the most significant bit of the word. That offset is the low three bits of the absolute stream bit position; the byte index (position shifted right by three) selects which word is loaded and is handled outside this unit.

The unit clears every bit to the left of the offset, then shifts the word right so that the last requested bit lands in bit 0. The field comes back right-aligned with zeros above it. A single issue strobe starts an extract. The result and an error flag are registered on that clock edge. No handshake is needed, because the unit always accepts.

Top module: `bfx_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first issue, `field_o` is zero and `err_o` is 0. Asserting `rst_n` low clears both outputs at once, without waiting for a clock edge.
- R2: For a legal length L (1 to 25) and offset F, the result equals stream bits [31-F] down to [32-F-L], placed in `field_o[L-1:0]`. All bits of `field_o` from bit L upward are zero, and `err_o` is 0.
- R3: The offset F is taken from control bits 10..8 and the length L from control bits 7..0. For example, control 0x00000304 on stream 0xF0F0F0F0 gives 0x8.
- R4: A length of 0 returns zero with `err_o` 0, for every offset.
- R5: A length from 26 to 255 sets `err_o` to 1 and returns zero. Whenever `err_o` is 1, `field_o` is zero.
- R6: At offset 7 and length 25 the field reaches bit 0 of the stream word. Stream 0x01FFFFFF gives 0x01FFFFFF, and stream 0xFE000001 gives 0x00000001.
- R7: Control bits 31..11 have no effect on the result or on the error flag.
- R8: While `issue_i` is low, `field_o` and `err_o` keep their values, whatever the operands do.
- R9: The outputs reflect an issued request right after the clock edge that samples `issue_i` high. The unit has one cycle of latency and accepts a new request on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| issue_i | input | 1 | Starts an extract with the operands present on this cycle |
| stream_i | input | 32 | Big-endian stream word |
| ctrl_i | input | 32 | Control word: offset in bits 10..8, length in bits 7..0 |
| field_o | output | 32 | Extracted field, right-aligned, zero-filled above |
| err_o | output | 1 | Set when the last issued length exceeded 25 |

## Verification
There is only one register stage, so any fault in the mask, the shifter stages or the control decode shows in `field_o` or `err_o` on the cycle after the issue that triggers it. A barrel stage stuck in one position corrupts only those fields whose shift amount uses that stage. For that reason the bench sweeps every offset against every length from 0 to 31 over several stream patterns, which drives each stage both ways. A register that fails to hold shows as changed outputs during cycles with no issue. Misrouted control bits show as a wrong offset, a wrong length or a spurious error flag.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int WORD_W  = 32;
  localparam int OFS_W   = 3;
  localparam int LEN_W   = 8;
  localparam int OFS_LSB = LEN_W;
  localparam int SH_W    = $clog2(WORD_W);
  localparam int MAX_LEN = WORD_W - (2 ** OFS_W) + 1;

  typedef enum logic [1:0] {
    LEN_ZERO = 2'd0,
    LEN_OK   = 2'd1,
    LEN_BAD  = 2'd2
  } len_class_e;
endpackage

// File: rtl/bfx_rst_sync.sv
module bfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bfx_ctrl_decode.sv
module bfx_ctrl_decode
  import bfx_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int OW   = OFS_W,
  parameter int LW   = LEN_W,
  parameter int SW   = SH_W,
  parameter int LMAX = MAX_LEN
) (
  input  logic [W-1:0]  ctrl,
  output logic [OW-1:0] ofs,
  output logic [LW-1:0] len,
  output len_class_e    cls,
  output logic [SW-1:0] shamt
);
  localparam int OLSB = LW;
  localparam int TW   = LW + 1;

  logic [TW-1:0] tail;
  logic          unused_hi;

  assign unused_hi = ^ctrl[W-1:OLSB+OW];

  always_comb begin
    ofs  = ctrl[OLSB +: OW];
    len  = ctrl[LW-1:0];
    tail = TW'(W) - TW'(ofs) - TW'(len);
    if (len == '0)                  cls = LEN_ZERO;
    else if (len > LW'(LMAX))       cls = LEN_BAD;
    else                            cls = LEN_OK;
    shamt = (cls == LEN_OK) ? tail[SW-1:0] : '0;
  end

  // R2: a legal request never needs a shift of a full word or more
  always_comb begin
    if (cls == LEN_OK) begin
      a_tail_fits_r2 : assert (tail < TW'(W));
    end
  end
endmodule

// File: rtl/bfx_shifter.sv
module bfx_shifter
  import bfx_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int OW = OFS_W,
  parameter int SW = SH_W
) (
  input  logic [W-1:0]  word,
  input  logic [OW-1:0] ofs,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  field
);
  logic [W-1:0] keep_mask;
  logic [W-1:0] stage [SW+1];

  assign keep_mask = {W{1'b1}} >> ofs;
  assign stage[0]  = word & keep_mask;

  genvar gi;
  generate
    for (gi = 0; gi < SW; gi++) begin : g_barrel
      localparam int STEP = 1 << gi;
      assign stage[gi+1] = shamt[gi] ? (stage[gi] >> STEP) : stage[gi];
    end
  endgenerate

  assign field = stage[SW];
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int OW   = OFS_W,
  parameter int LW   = LEN_W,
  parameter int LMAX = MAX_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_i,
  input  logic [W-1:0] stream_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] field_o,
  output logic         err_o
);
  localparam int SW = $clog2(W);

  logic          rst_sync_n;
  logic [OW-1:0] ofs;
  logic [LW-1:0] len;
  len_class_e    cls;
  logic [SW-1:0] shamt;
  logic [W-1:0]  shifted;

  logic [W-1:0]  field_q, field_d;
  logic          err_q, err_d;
  logic          load_en;

  bfx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bfx_ctrl_decode #(.W(W), .OW(OW), .LW(LW), .SW(SW), .LMAX(LMAX)) u_dec (
    .ctrl  (ctrl_i),
    .ofs   (ofs),
    .len   (len),
    .cls   (cls),
    .shamt (shamt)
  );

  bfx_shifter #(.W(W), .OW(OW), .SW(SW)) u_sh (
    .word  (stream_i),
    .ofs   (ofs),
    .shamt (shamt),
    .field (shifted)
  );

  assign load_en = issue_i;

  always_comb begin
    field_d = field_q;
    err_d   = err_q;
    if (load_en) begin
      unique case (cls)
        LEN_OK:  begin field_d = shifted; err_d = 1'b0; end
        LEN_BAD: begin field_d = '0;      err_d = 1'b1; end
        default: begin field_d = '0;      err_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      field_q <= '0;
      err_q   <= 1'b0;
    end else if (load_en) begin
      field_q <= field_d;
      err_q   <= err_d;
    end
  end

  assign field_o = field_q;
  assign err_o   = err_q;

  p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_i |=> ($stable(field_o) && $stable(err_o)));

  p_err_zero_r5 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> (field_o == '0));

  p_err_set_r5 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && (ctrl_i[LW-1:0] > LW'(LMAX))) |=> err_o);

  p_zero_len_r4 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && (ctrl_i[LW-1:0] == '0)) |=> ((field_o == '0) && !err_o));

  p_width_r2 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && (ctrl_i[LW-1:0] != '0) && (ctrl_i[LW-1:0] <= LW'(LMAX)))
      |=> (((field_o >> $past(ctrl_i[LW-1:0])) == '0) && !err_o));
endmodule

// File: tb/bfx_unit_test.sv
module bfx_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 25;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [31:0] stream_i;
  logic [31:0] ctrl_i;
  logic [31:0] field_o;
  logic        err_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfx_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .stream_i (stream_i),
    .ctrl_i   (ctrl_i),
    .field_o  (field_o),
    .err_o    (err_o)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input int f, input int l);
    longint unsigned v;
    if (l == 0 || l > MAXL) return 32'd0;
    v = longint'(s) >> (32 - f - l);
    return 32'(v & ((64'd1 << l) - 1));
  endfunction

  function automatic logic [31:0] pattern(input int p);
    case (p)
      0:       return 32'hA5C3_0F96;
      1:       return 32'hFFFF_FFFF;
      2:       return 32'h8000_0001;
      default: return 32'h3B6E_D215;
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    stream_i = s;
    ctrl_i   = c;
    issue_i  = 1'b1;
    @(negedge clk);
    issue_i  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ref_f;
    logic        ref_e;
    rst_n = 1'b0; issue_i = 1'b0; stream_i = '0; ctrl_i = '0;
    repeat (3) @(negedge clk);
    check32("R1 reset field", field_o, 32'd0);
    check32("R1 reset err", {31'd0, err_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check32("R1 post-release field", field_o, 32'd0);

    // R3 explicit packing example
    issue(32'hF0F0_F0F0, 32'h0000_0304);
    check32("R3 packed ctrl", field_o, 32'h8);

    // R6 boundary at offset 7, length 25
    issue(32'h01FF_FFFF, {21'd0, 3'd7, 8'd25});
    check32("R6 full tail", field_o, 32'h01FF_FFFF);
    issue(32'hFE00_0001, {21'd0, 3'd7, 8'd25});
    check32("R6 low bit", field_o, 32'h1);

    // R2 R4 R5 R7: sweep offsets and lengths 0..31 over patterns
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 8; f++) begin
        for (int l = 0; l < 32; l++) begin
          logic [20:0] junk;
          junk = (p == 3) ? 21'h1A_BCDE : 21'd0;
          issue(pattern(p), {junk, 3'(f), 8'(l)});
          if (l == 0) begin
            check32("R4 zero length field", field_o, 32'd0);
            check32("R4 zero length err", {31'd0, err_o}, 32'd0);
          end else if (l > MAXL) begin
            check32("R5 bad length field", field_o, 32'd0);
            check32("R5 bad length err", {31'd0, err_o}, 32'd1);
          end else begin
            check32((p == 3) ? "R7 R2 junk ctrl field" : "R2 field", field_o, model(pattern(p), f, l));
            check32("R2 err clear", {31'd0, err_o}, 32'd0);
          end
        end
      end
    end

    // R5 upper lengths
    for (int l = 32; l < 256; l += 7) begin
      issue(32'hDEAD_BEEF, {21'd0, 3'(l % 8), 8'(l)});
      check32("R5 long length err", {31'd0, err_o}, 32'd1);
      check32("R5 long length field", field_o, 32'd0);
    end

    // R7 same request with and without upper control bits
    issue(32'h1234_5678, {21'd0, 3'd5, 8'd11});
    ref_f = field_o; ref_e = err_o;
    issue(32'h1234_5678, {21'h1F_FFFF, 3'd5, 8'd11});
    check32("R7 upper bits ignored field", field_o, ref_f);
    check32("R7 upper bits ignored err", {31'd0, err_o}, {31'd0, ref_e});

    // R8 hold with no issue, R9 latency of one edge
    issue(32'hCAFE_F00D, {21'd0, 3'd2, 8'd20});
    check32("R9 one-cycle result", field_o, model(32'hCAFE_F00D, 2, 20));
    @(negedge clk);
    stream_i = 32'h0; ctrl_i = {21'd0, 3'd0, 8'd200};
    repeat (3) @(negedge clk);
    check32("R8 hold field", field_o, model(32'hCAFE_F00D, 2, 20));
    check32("R8 hold err", {31'd0, err_o}, 32'd0);
    issue(32'h0, {21'd0, 3'd0, 8'd99});
    ctrl_i = {21'd0, 3'd1, 8'd4}; stream_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check32("R8 hold err flag", {31'd0, err_o}, 32'd1);

    // R9 back-to-back issues
    @(negedge clk);
    stream_i = 32'hFFFF_0000; ctrl_i = {21'd0, 3'd0, 8'd16}; issue_i = 1'b1;
    @(negedge clk);
    check32("R9 back-to-back first", field_o, 32'hFFFF);
    stream_i = 32'hFFFF_0000; ctrl_i = {21'd0, 3'd4, 8'd16};
    @(negedge clk);
    issue_i = 1'b0;
    check32("R9 back-to-back second", field_o, 32'hFFF0);

    // R1 asynchronous clear mid-run
    issue(32'hFFFF_FFFF, {21'd0, 3'd0, 8'd25});
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check32("R1 async clear field", field_o, 32'd0);
    check32("R1 async clear err", {31'd0, err_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule